// File: doc/BRIEF.md
# Double-Latched Programmable Frequency Divider

This block divides a count clock (in a synthesizer loop, the already prescaled oscillator) by a 15-bit ratio N. It produces one output pulse every N clocks. It also produces a half-rate square wave for test observation.

The ratio comes from a bus receiver. The receiver writes the ratio into a front holding register at any moment, with no regard to where the counter is in its cycle. The ratio reaches the counter only through a second, back register. The back register loads from the front register only at a terminal count, and only after a transfer request has been raised. The request is the receiver's start-detected pulse. The request is held pending until the next terminal count, so the count in progress always finishes at the old ratio. A writing controller therefore writes the ratio and then issues a bus start, either a new transaction or a repeated start, to commit the ratio.

The counter is a down-counter. It reloads from the back register, or from the front register on a transfer edge, each time it reaches zero. After reset both registers hold 256.

Top module: `tune_divider`

## Requirements
- R1: The output `div_pulse_o` is high for exactly one clock per period. Once a ratio N is committed, consecutive pulses are exactly N clocks apart. N is the unsigned binary value of `ratio_i[14:0]`, with bit 14 weighing 16384 and bit 0 weighing 1.
- R2: A written value below 17, including 0, is stored and used as 17.
- R3: The extreme ratios 17 and 32767 reload correctly and give periods of exactly 17 and 32767 clocks.
- R4: While reset is applied, both outputs are low. After reset, the divider runs at ratio 256 until a transfer commits another value, whatever was written before the reset.
- R5: A write to the front register with no transfer request leaves the output period unchanged.
- R6: A `bus_start_i` pulse makes the front register's value govern the counter from the next terminal count on. The period in progress completes at the old ratio.
- R7: A `bus_start_i` pulse in the same clock as a terminal count is not applied at that terminal count. It is applied at the following one, so one more full period runs at the old ratio.
- R8: If a write lands in the clock of a terminal count that performs a pending transfer, the transfer takes the value held before that write. The newly written value waits for a later transfer request.
- R9: `div_half_o` changes in the clock after each output pulse and holds steady at all other times. It therefore runs at half the pulse rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Count clock (prescaled oscillator) |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ratio_wr_i | input | 1 | Write strobe for the front ratio register |
| ratio_i | input | 15 | Ratio value written with `ratio_wr_i` |
| bus_start_i | input | 1 | One-clock start-detected pulse; requests a front-to-back transfer |
| div_pulse_o | output | 1 | One-clock pulse per divided period (terminal count) |
| div_half_o | output | 1 | Toggles after each pulse; divided output over two |

## Verification
Three events can land on the same clock edge: the terminal count, a start request, and a ratio write. The bench drives a start request, and separately a write with a transfer already pending, in the very cycle where `div_pulse_o` is observed high. The result is judged by the measured pulse-to-pulse intervals that follow. After a start on the terminal cycle, one more old-ratio period must run before the new ratio. After a write on a transferring terminal cycle, the earlier value must take over and the new one must stay parked.

// File: rtl/tune_divider_pkg.sv
package tune_divider_pkg;
  // Default geometry of the divider
  localparam int unsigned DIV_W       = 15;
  localparam int unsigned DIV_MIN     = 17;
  localparam int unsigned DIV_RESET   = 256;
  localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/tune_divider_rst_sync.sv
module tune_divider_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/tune_divider_ratio_latch.sv
module tune_divider_ratio_latch #(
  parameter int unsigned W           = 15,
  parameter int unsigned MIN_RATIO   = 17,
  parameter int unsigned RESET_RATIO = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  input  logic         start_i,
  input  logic         tc_i,
  output logic [W-1:0] front_o,
  output logic [W-1:0] back_o,
  output logic         pending_o,
  output logic [W-1:0] reload_o
);
  localparam logic [W-1:0] MIN_V   = W'(MIN_RATIO);
  localparam logic [W-1:0] RESET_V = W'(RESET_RATIO);

  logic [W-1:0] front_q, front_d;
  logic [W-1:0] back_q,  back_d;
  logic         pend_q,  pend_d;
  logic         front_en, back_en;

  // next-state
  always_comb begin
    front_en = wr_i;
    front_d  = (data_i < MIN_V) ? MIN_V : data_i;
    back_en  = tc_i & pend_q;
    back_d   = front_q;
    pend_d   = start_i | (pend_q & ~tc_i);
    reload_o = back_en ? front_q : back_q;
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       front_q <= RESET_V;
    else if (front_en) front_q <= front_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      back_q <= RESET_V;
    else if (back_en) back_q <= back_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= pend_d;
  end

  assign front_o   = front_q;
  assign back_o    = back_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/tune_divider_counter.sv
module tune_divider_counter #(
  parameter int unsigned W           = 15,
  parameter int unsigned RESET_RATIO = 256
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] reload_i,
  output logic         tc_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE     = W'(1);
  localparam logic [W-1:0] RESET_C = W'(RESET_RATIO - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         tc;

  always_comb begin
    tc    = (cnt_q == '0);
    cnt_d = tc ? (reload_i - ONE) : (cnt_q - ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= RESET_C;
    else         cnt_q <= cnt_d;
  end

  assign tc_o  = tc;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/tune_divider_toggle.sv
module tune_divider_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = ~q_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= 1'b0;
    else if (en_i) q_q <= q_d;
  end

  assign q_o = q_q;
endmodule

// File: rtl/tune_divider.sv
module tune_divider #(
  parameter int unsigned W           = tune_divider_pkg::DIV_W,
  parameter int unsigned MIN_RATIO   = tune_divider_pkg::DIV_MIN,
  parameter int unsigned RESET_RATIO = tune_divider_pkg::DIV_RESET,
  parameter int unsigned SYNC_STAGES = tune_divider_pkg::SYNC_STAGES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ratio_wr_i,
  input  logic [W-1:0] ratio_i,
  input  logic         bus_start_i,
  output logic         div_pulse_o,
  output logic         div_half_o
);
  logic         rst_n_s;
  logic         tc;
  logic [W-1:0] cnt;
  logic [W-1:0] ratio_a;
  logic [W-1:0] ratio_b;
  logic [W-1:0] reload;
  logic         pending;
  logic         half_q;

  tune_divider_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  tune_divider_ratio_latch #(
    .W(W), .MIN_RATIO(MIN_RATIO), .RESET_RATIO(RESET_RATIO)
  ) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_s),
    .wr_i      (ratio_wr_i),
    .data_i    (ratio_i),
    .start_i   (bus_start_i),
    .tc_i      (tc),
    .front_o   (ratio_a),
    .back_o    (ratio_b),
    .pending_o (pending),
    .reload_o  (reload)
  );

  tune_divider_counter #(.W(W), .RESET_RATIO(RESET_RATIO)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .reload_i (reload),
    .tc_o     (tc),
    .cnt_o    (cnt)
  );

  tune_divider_toggle u_half (
    .clk_i  (clk_i),
    .rst_ni (rst_n_s),
    .en_i   (tc),
    .q_o    (half_q)
  );

  assign div_pulse_o = tc;
  assign div_half_o  = half_q;
endmodule

// File: rtl/tune_divider_chk.sv
module tune_divider_chk #(
  parameter int unsigned W         = 15,
  parameter int unsigned MIN_RATIO = 17
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         tc,
  input logic [W-1:0] cnt,
  input logic [W-1:0] ratio_a,
  input logic [W-1:0] ratio_b,
  input logic         pending,
  input logic         half,
  input logic         start
);
  a_r1_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_n)
    tc |=> !tc);

  a_r2_front_floor: assert property (@(posedge clk_i) disable iff (!rst_n)
    ratio_a >= W'(MIN_RATIO));

  a_r3_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt < ratio_b);

  a_r5_back_holds_midcount: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tc |=> $stable(ratio_b));

  a_r6_back_takes_front: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tc && pending) |=> (ratio_b == $past(ratio_a)));

  a_r7_start_arms: assert property (@(posedge clk_i) disable iff (!rst_n)
    start |=> pending);

  a_r6_tc_consumes: assert property (@(posedge clk_i) disable iff (!rst_n)
    (tc && !start) |=> !pending);

  a_r9_half_flips: assert property (@(posedge clk_i) disable iff (!rst_n)
    tc |=> (half != $past(half)));

  a_r9_half_steady: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tc |=> $stable(half));
endmodule

bind tune_divider tune_divider_chk #(.W(W), .MIN_RATIO(MIN_RATIO)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n_s),
  .tc      (tc),
  .cnt     (cnt),
  .ratio_a (ratio_a),
  .ratio_b (ratio_b),
  .pending (pending),
  .half    (half_q),
  .start   (bus_start_i)
);

// File: tb/tune_divider_test.sv
module tune_divider_test;
  logic        clk;
  logic        rst_n;
  logic        wr;
  logic [14:0] din;
  logic        start;
  logic        pulse;
  logic        half;

  int nchk  = 0;
  int nfail = 0;
  int ncyc  = 0;
  int lastp = 0;
  int per   = 0;
  int npul  = 0;
  bit done  = 0;

  // {written value, expected period}
  localparam logic [31:0] VECS [7] = '{
    {16'd100,   16'd100},
    {16'd17,    16'd17},
    {16'd32767, 16'd32767},
    {16'd0,     16'd17},
    {16'd16,    16'd17},
    {16'd1365,  16'd1365},
    {16'd1000,  16'd1000}
  };

  tune_divider uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ratio_wr_i  (wr),
    .ratio_i     (din),
    .bus_start_i (start),
    .div_pulse_o (pulse),
    .div_half_o  (half)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // pulse interval monitor, sampled on falling edges
  always @(negedge clk) begin
    ncyc = ncyc + 1;
    if (pulse) begin
      per   = ncyc - lastp;
      lastp = ncyc;
      npul  = npul + 1;
    end
  end

  task automatic check(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulses(int k);
    int tgt;
    tgt = npul + k;
    wait (npul >= tgt);
  endtask

  // drive now, release at next falling edge
  task automatic drive(bit w, int v, bit s);
    wr    = w;
    din   = 15'(v);
    start = s;
    @(negedge clk);
    wr    = 1'b0;
    start = 1'b0;
  endtask

  task automatic commit(int v);
    wait_pulses(1);
    @(negedge clk);
    drive(1'b1, v, 1'b1);
    wait_pulses(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int prev;
    int h0;
    bit steady;
    rst_n = 1'b0; wr = 1'b0; din = '0; start = 1'b0;
    repeat (4) @(negedge clk);
    check("R4 pulse in reset", int'(pulse), 0);
    check("R4 half in reset", int'(half), 0);
    rst_n = 1'b1;

    // R4 default ratio and R9 toggle timing
    wait_pulses(1);
    check("R9 half before first pulse", int'(half), 0);
    @(negedge clk);
    check("R9 half after pulse", int'(half), 1);
    wait_pulses(1);
    check("R4 reset ratio 256", per, 256);

    // table of ratios: R1 / R2 / R3 / R6
    prev = 256;
    for (int i = 0; i < 7; i++) begin
      int vin;
      int vexp;
      vin  = int'(VECS[i][31:16]);
      vexp = int'(VECS[i][15:0]);
      wait_pulses(1);
      @(negedge clk);
      drive(1'b1, vin, 1'b1);
      wait_pulses(1);
      check("R6 old period completes", per, prev);
      wait_pulses(1);
      if (vexp != vin)                      check("R2 clamp to 17", per, vexp);
      else if (vin == 17 || vin == 32767)   check("R3 extreme ratio", per, vexp);
      else                                  check("R1 ratio period", per, vexp);
      prev = vexp;
    end

    // R5: write without transfer request
    commit(40);
    check("R1 ratio 40", per, 40);
    @(negedge clk);
    drive(1'b1, 60, 1'b0);
    wait_pulses(1);
    check("R5 write alone no effect", per, 40);
    wait_pulses(1);
    check("R5 write alone still no effect", per, 40);

    // R7: start on the terminal-count cycle
    wait_pulses(1);
    drive(1'b0, 0, 1'b1);
    wait_pulses(1);
    check("R7 start on tc not applied", per, 40);
    wait_pulses(1);
    check("R7 start applied next tc", per, 60);

    // R8: write on a transferring terminal-count cycle
    wait_pulses(1);
    @(negedge clk);
    drive(1'b1, 45, 1'b1);
    wait_pulses(1);
    drive(1'b1, 70, 1'b0);
    wait_pulses(1);
    check("R8 transfer takes earlier value", per, 45);
    wait_pulses(1);
    check("R8 late write stays parked", per, 45);
    @(negedge clk);
    drive(1'b0, 0, 1'b1);
    wait_pulses(2);
    check("R6 parked value committed", per, 70);

    // R9: steady between pulses
    wait_pulses(1);
    h0 = int'(half);
    @(negedge clk);
    check("R9 toggles after pulse", int'(half), 1 - h0);
    steady = 1'b1;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (int'(half) != 1 - h0) steady = 1'b0;
    end
    check("R9 steady mid-period", int'(steady), 1);

    // R4: reset mid-run restores 256 despite pending state
    @(negedge clk);
    drive(1'b1, 30, 1'b1);
    rst_n = 1'b0;
    @(negedge clk);
    check("R4 pulse low in reset", int'(pulse), 0);
    check("R4 half low in reset", int'(half), 0);
    rst_n = 1'b1;
    wait_pulses(2);
    check("R4 ratio 256 after reset", per, 256);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule